// File: doc/BRIEF.md
# Sixteen-Digit Segment Display Controller

This block drives a row of sixteen alphanumeric digits, each built from sixteen segments. A processor writes a character code into one of sixteen consecutive byte locations of its address space. The block turns the code into an index into a character generator. The generator is two byte-wide lookup tables: one supplies the low eight segment lines and the other supplies the high eight. The high byte is reordered to match the wiring of the digit. The whole pattern is then inverted, because the segments are active low, and latched into the register of that digit.

A scan engine shows the digits one after another. It drives a one-hot, active-low digit enable and the sixteen segment lines of the enabled digit. It advances to the next digit after a fixed number of clocks set by a parameter. The lookup tables are filled through a separate load port, either at start-up or from a test environment.

Top module: `segdisp_top`

## Requirements
- R1: A bus write whose address lies in the 16-byte window starting at 0x7800 (0x7800 to 0x780F) updates one digit register. Address bits [3:0] select the digit.
- R2: A bus write to any address outside that window changes no digit register. This includes 0x0000, 0x3FFF, 0x77FF, 0x7810 and 0x8000.
- R3: The table index is {code[6:5], 0, code[4:0]}. Code bit 7 has no effect on the result, and index bit 5 is always zero.
- R4: Glyph bits [7:0] come from table 0 (load select 0) and glyph bits [15:8] come from table 1 (load select 1). Both tables are read at the same index.
- R5: Glyph bits [7:0] are stored in place. Stored bits 15 down to 8 take glyph bits 13, 11, 9, 15, 14, 10, 12 and 8, in that order.
- R6: The reordered 16-bit pattern is stored inverted, so a set table bit gives a low, lit segment.
- R7: A digit register takes its new value on the clock edge that samples the write. It then holds that value until the same digit is written again.
- R8: Reset sets all sixteen digit registers to 16'hFFFF (all segments off) and selects digit 0 for the scan.
- R9: The scan enable is one-hot and active low. It starts at digit 0, stays on each digit for SCAN_DIV clocks and steps 0, 1, … 15, then wraps to 0.
- R10: The segment output always equals the register of the enabled digit. A write to the digit being shown appears on the next clock, while that digit is still enabled.
- R11: Writing either lookup table through the load port leaves every latched digit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Processor write strobe |
| busAddr | input | ADDR_W | Processor byte address |
| busData | input | 8 | Character code |
| tblWrEn | input | 1 | Lookup-table load strobe |
| tblSel | input | 1 | Table to load: 0 = low segment byte, 1 = high segment byte |
| tblAddr | input | 8 | Table entry to load |
| tblData | input | 8 | Table entry value |
| scanEnN | output | 16 | One-hot active-low digit enable |
| scanSeg | output | 16 | Active-low segment lines of the enabled digit |

## Verification
The tables are filled with two different arithmetic patterns, so every table entry is distinct from its neighbours. All 256 character codes are then swept across the sixteen digits. This sweep separates the low and high tables, exposes a wrong or missing index gap, and shows whether code bit 7 leaks into the index. It also catches any misplaced bit in the high-byte reordering or the inversion. A further set of writes is aimed at addresses just outside the window, and the tables are reloaded with other contents, to show that neither disturbs the latched digits. A write timed into the first cycle a digit is shown tells correct latency apart from off-by-one behaviour, and the scan order is traced clock by clock right after reset.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;
  localparam int DIGITS    = 16;
  localparam int DIG_IDX_W = $clog2(DIGITS);
  localparam int SEG_W     = 16;
  localparam int CODE_W    = 8;
  localparam int TBL_DEPTH = 256;
  localparam int TBL_AW    = $clog2(TBL_DEPTH);
  localparam int TBL_COUNT = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 digitWr;
    logic [DIG_IDX_W-1:0] digitSel;
    logic [DIG_IDX_W-1:0] scanIdx;
  } ctrlStrobe_t;

  // Route the high byte to the digit's wiring; low byte passes through
  function automatic logic [SEG_W-1:0] reorderHigh(input logic [SEG_W-1:0] g);
    return {g[13], g[11], g[9], g[15], g[14], g[10], g[12], g[8], g[7:0]};
  endfunction
endpackage

// File: rtl/segdisp_ctrl.sv
module segdisp_ctrl
  import segdisp_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h7800,
  parameter int              SCAN_DIV  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  localparam int DIV_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;

  logic                 inWindow;
  logic                 scanTick;
  logic [DIG_IDX_W-1:0] scanIdxQ;

  // Decode of the 16-byte digit window
  assign inWindow = (busAddr[ADDR_W-1:DIG_IDX_W] == BASE_ADDR[ADDR_W-1:DIG_IDX_W]);

  generate
    if (SCAN_DIV <= 1) begin : gNoDiv
      assign scanTick = 1'b1;
    end else begin : gDiv
      logic [DIV_W-1:0] divQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                             divQ <= '0;
        else if (divQ == DIV_W'(SCAN_DIV - 1)) divQ <= '0;
        else                                   divQ <= divQ + 1'b1;
      end
      assign scanTick = (divQ == DIV_W'(SCAN_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         scanIdxQ <= '0;
    else if (scanTick) scanIdxQ <= scanIdxQ + 1'b1;
  end

  always_comb begin
    strobe.digitWr  = busWrEn && inWindow;
    strobe.digitSel = busAddr[DIG_IDX_W-1:0];
    strobe.scanIdx  = scanIdxQ;
  end
endmodule

// File: rtl/segdisp_dp.sv
module segdisp_dp
  import segdisp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CODE_W-1:0] busData,
  input  logic              tblWrEn,
  input  logic              tblSel,
  input  logic [TBL_AW-1:0] tblAddr,
  input  logic [7:0]        tblData,
  output logic [DIGITS-1:0] scanEnN,
  output logic [SEG_W-1:0]  scanSeg
);
  logic [TBL_AW-1:0]             charIdx;
  logic [TBL_COUNT-1:0][7:0]     tblRd;
  logic [SEG_W-1:0]              latchVal;
  logic [DIGITS-1:0][SEG_W-1:0]  digitQ;

  // Index: code[6:5] move up one place, index bit 5 is a gap, code[7] drops out
  assign charIdx = ((busData << 1) & 8'hC0) | (busData & 8'h1F);

  generate
    for (genvar t = 0; t < TBL_COUNT; t++) begin : gTbl
      logic [7:0] mem [TBL_DEPTH];
      always_ff @(posedge clk) begin
        if (tblWrEn && (tblSel == 1'(t))) mem[tblAddr] <= tblData;
      end
      assign tblRd[t] = mem[charIdx];
    end
  endgenerate

  assign latchVal = ~reorderHigh({tblRd[1], tblRd[0]});

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : gDigit
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          digitQ[d] <= '1;
        else if (strobe.digitWr && (strobe.digitSel == DIG_IDX_W'(d)))
          digitQ[d] <= latchVal;
      end
    end
  endgenerate

  assign scanEnN = ~(DIGITS'(1) << strobe.scanIdx);
  assign scanSeg = digitQ[strobe.scanIdx];
endmodule

// File: rtl/segdisp_top.sv
module segdisp_top
  import segdisp_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h7800,
  parameter int                SCAN_DIV  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busData,
  input  logic              tblWrEn,
  input  logic              tblSel,
  input  logic [7:0]        tblAddr,
  input  logic [7:0]        tblData,
  output logic [15:0]       scanEnN,
  output logic [15:0]       scanSeg
);
  ctrlStrobe_t strobe;

  segdisp_ctrl #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .SCAN_DIV (SCAN_DIV)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  segdisp_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .busData(busData),
    .tblWrEn(tblWrEn),
    .tblSel (tblSel),
    .tblAddr(tblAddr),
    .tblData(tblData),
    .scanEnN(scanEnN),
    .scanSeg(scanSeg)
  );
endmodule

// File: rtl/segdisp_chk.sv
module segdisp_chk
  import segdisp_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h7800
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              tblWrEn,
  input logic [15:0]       scanEnN,
  input logic [15:0]       scanSeg
);
  logic outsideWr;
  assign outsideWr = busWrEn &&
    (busAddr[ADDR_W-1:DIG_IDX_W] != BASE_ADDR[ADDR_W-1:DIG_IDX_W]);

  assert_enable_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~scanEnN) == 1);

  assert_scan_rotates_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(scanEnN) |-> scanEnN == {$past(scanEnN[14:0]), $past(scanEnN[15])});

  assert_reset_blank_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (scanSeg == 16'hFFFF && scanEnN == 16'hFFFE));

  assert_outside_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    outsideWr |=> ($stable(scanEnN) -> $stable(scanSeg)));

  assert_tbl_load_keeps_R11: assert property (@(posedge clk) disable iff (!rstN)
    (tblWrEn && !busWrEn) |=> ($stable(scanEnN) -> $stable(scanSeg)));
endmodule

bind segdisp_top segdisp_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busWrEn(busWrEn),
  .busAddr(busAddr),
  .tblWrEn(tblWrEn),
  .scanEnN(scanEnN),
  .scanSeg(scanSeg)
);

// File: tb/segdisp_top_bench.sv
module segdisp_top_bench;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busData = '0;
  logic        tblWrEn = 1'b0;
  logic        tblSel = 1'b0;
  logic [7:0]  tblAddr = '0;
  logic [7:0]  tblData = '0;
  logic [15:0] scanEnN;
  logic [15:0] scanSeg;

  int checks = 0;
  int failures = 0;
  logic [7:0] shadow [16];

  always #2 clk = ~clk;

  segdisp_top #(.SCAN_DIV(DIV)) u_segdisp_top (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busData(busData),
    .tblWrEn(tblWrEn), .tblSel(tblSel), .tblAddr(tblAddr), .tblData(tblData),
    .scanEnN(scanEnN), .scanSeg(scanSeg)
  );

  function automatic logic [7:0] tblVal(input bit sel, input logic [7:0] i, input logic [7:0] salt);
    if (sel) return (i * 8'd91) ^ 8'h5A ^ salt;
    else     return (i * 8'd37) + 8'd11 + salt;
  endfunction

  function automatic logic [15:0] expGlyph(input logic [7:0] code, input logic [7:0] salt);
    logic [7:0] idx;
    logic [15:0] g;
    idx = {code[6:5], 1'b0, code[4:0]};             // R3
    g = {tblVal(1'b1, idx, salt), tblVal(1'b0, idx, salt)};   // R4
    g = {g[13], g[11], g[9], g[15], g[14], g[10], g[12], g[8], g[7:0]}; // R5
    return ~g;                                       // R6
  endfunction

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadTables(input logic [7:0] salt);
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 256; i++) begin
        @(negedge clk);
        tblWrEn = 1'b1; tblSel = s[0]; tblAddr = i[7:0]; tblData = tblVal(s[0], i[7:0], salt);
      end
    end
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readDigit(input int d, output logic [15:0] v);
    while (scanEnN[d] !== 1'b0) @(negedge clk);
    v = scanSeg;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0] code;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9: scan order from release, SCAN_DIV clocks per digit
    for (int n = 0; n < 40; n++) begin
      check16("R9 scan enable", scanEnN, ~(16'h1 << ((n / DIV) % 16)));
      @(negedge clk);
    end
    // R8: all digits blank after reset
    for (int d = 0; d < 16; d++) begin
      readDigit(d, v);
      check16("R8 reset blank", v, 16'hFFFF);
    end

    loadTables(8'h00);
    // R1 R3 R4 R5 R6: sweep every code over all digits
    for (int b = 0; b < 16; b++) begin
      for (int k = 0; k < 16; k++) begin
        code = 8'(b * 16 + ((k * 7 + b) % 16));
        shadow[k] = code;
        busWrite(16'h7800 + 16'(k), code);
      end
      for (int k = 0; k < 16; k++) begin
        readDigit(k, v);
        check16("R1/R3/R4/R5/R6 glyph", v, expGlyph(shadow[k], 8'h00));
      end
    end
    // R3: code bit 7 ignored, distinct codes with and without it match
    busWrite(16'h7802, 8'h35);
    busWrite(16'h7803, 8'hB5);
    begin
      logic [15:0] a2, a3;
      readDigit(2, a2);
      readDigit(3, a3);
      check16("R3 bit7 ignored", a3, a2);
    end

    // R2: outside writes ignored
    for (int k = 0; k < 16; k++) begin
      shadow[k] = 8'(k * 13 + 1);
      busWrite(16'h7800 + 16'(k), shadow[k]);
    end
    busWrite(16'h0000, 8'h7F);
    busWrite(16'h3FFF, 8'h11);
    busWrite(16'h77FF, 8'h22);
    busWrite(16'h7810, 8'h33);
    busWrite(16'h8000, 8'h44);
    busWrite(16'hF805, 8'h55);
    busWrite(16'h0805, 8'h66);
    for (int k = 0; k < 16; k++) begin
      readDigit(k, v);
      check16("R2 outside ignored", v, expGlyph(shadow[k], 8'h00));
    end

    // R11: table reload keeps latched digits
    loadTables(8'hA7);
    for (int k = 0; k < 16; k++) begin
      readDigit(k, v);
      check16("R11 table load keeps digits", v, expGlyph(shadow[k], 8'h00));
    end
    // new table contents are used by later writes (R4)
    busWrite(16'h7809, 8'h4C);
    readDigit(9, v);
    check16("R4 reloaded table", v, expGlyph(8'h4C, 8'hA7));
    shadow[9] = 8'h4C;

    // R10 R7: write into first cycle the digit is shown
    begin
      bit prevOff = 1'b0;
      forever begin
        @(negedge clk);
        if (scanEnN[5] === 1'b0 && prevOff) break;
        prevOff = scanEnN[5];
      end
      check16("R10 before write", scanSeg, expGlyph(shadow[5], 8'h00));
      busWrEn = 1'b1; busAddr = 16'h7805; busData = 8'h6E;
      @(negedge clk);
      busWrEn = 1'b0;
      check16("R10 same digit still enabled", scanEnN, ~16'h0020);
      check16("R7 one clock latency", scanSeg, expGlyph(8'h6E, 8'hA7));
    end
    // R7: hold over other writes
    busWrite(16'h7806, 8'h01);
    busWrite(16'h7804, 8'h02);
    repeat (70) @(negedge clk);
    readDigit(5, v);
    check16("R7 hold", v, expGlyph(8'h6E, 8'hA7));

    // R8: reset mid-run blanks all digits
    doReset();
    check16("R8 scan at digit 0", scanEnN, 16'hFFFE);
    for (int d = 0; d < 16; d++) begin
      readDigit(d, v);
      check16("R8 reset after writes", v, 16'hFFFF);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule